// File: doc/BRIEF.md
# Multicast hash address filter

This block sits on the receive path and decides, for each incoming frame, whether its destination address passes the station's address filter. The destination address arrives as a stream of bytes, the first byte on the wire first, each with a valid strobe. A start strobe marks the first byte of a new address. While the bytes stream in, the block folds them into a reflected CRC-32. The top bits of that CRC select one bit of a hash table, which host logic writes as two half-width registers.

Bit 0 of the first address byte tells group addresses from individual ones. For a group address, the selected table bit gives the decision. An individual address passes only when it equals the programmed station address. A promiscuous control input makes every frame pass. The decision is registered and appears together with a one-cycle valid strobe in the cycle after the last address byte.

Top module: `mcast_hash_filter`

## Requirements
- R1: Reset drives decisionValid and accept low and clears both hash table halves, so that a group address sent after reset with promiscuous mode off is rejected.
- R2: The hash is a CRC-32 with reflected polynomial 0xEDB88320. It is initialised to all ones at each start strobe and updated with every address byte, least-significant bit first. Bytes are taken in arrival order, and stationAddr[47:40] corresponds to the first byte. The table index is CRC bits 31:26, with no final inversion.
- R3: Index values 32 to 63 select bit (index-32) of the high table half. Index values 0 to 31 select bit index of the low table half.
- R4: The hash lookup decides only for group addresses, that is, when bit 0 of the first address byte is 1. The group bit of any later byte has no effect on the choice.
- R5: With both table halves all ones, every group address is accepted. With both halves zero, every group address is rejected, unless promiscuous mode is on.
- R6: When promiscEn is high in the cycle of the last address byte, the frame is accepted whatever its address and the table contents.
- R7: With promiscuous mode off, an individual address is accepted exactly when all 48 bits equal stationAddr. The table contents have no effect on it.
- R8: decisionValid is high for exactly one cycle, the cycle after the sixth accepted byte, whatever idle cycles separate the bytes. accept is low whenever decisionValid is low.
- R9: A start strobe restarts address collection, even in the middle of an address. Bytes without a start strobe that arrive after the sixth byte or while idle are ignored and produce no decision.
- R10: A high tableHiWr or tableLoWr loads tableWrData into that half at the clock edge. The new value is used by every address whose last byte arrives in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | byteData carries an address byte this cycle |
| byteStart | input | 1 | With byteValid, marks the first address byte |
| byteData | input | 8 | Address byte |
| tableHiWr | input | 1 | Write strobe for the high table half |
| tableLoWr | input | 1 | Write strobe for the low table half |
| tableWrData | input | 32 | Data for a table half write |
| promiscEn | input | 1 | Accept every frame |
| stationAddr | input | 48 | Station address, first byte in bits 47:40 |
| decisionValid | output | 1 | One-cycle strobe marking a decision |
| accept | output | 1 | Frame passes the filter (valid with decisionValid) |

## Verification
A CRC register left with a stale or wrong value points at the wrong table bit. Only a table with a single set bit, or with a single cleared bit, exposes this on accept, and it shows in the decision cycle of that very address. A byte counter that is off by one shows at once: the decision strobe arrives early, late, twice, or never, so every frame checks it. The bench also checks that a restart in the middle of an address and bytes after the sixth leave no decision of their own.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  // Strobes from the control to the datapath, valid in the cycle of a byte.
  typedef struct packed {
    logic firstByte;
    logic nextByte;
    logic lastByte;
  } mhfStrobes_t;

  // Fold one byte into a reflected CRC, least significant bit first.
  function automatic logic [31:0] crcFeedByte(input logic [31:0] crcIn,
                                              input logic [7:0]  dataIn,
                                              input logic [31:0] poly);
    logic [31:0] c;
    c = crcIn;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ dataIn[b]) c = (c >> 1) ^ poly;
      else                  c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/mhf_ctrl.sv
module mhf_ctrl
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic        byteStart,
  output mhfStrobes_t strobes
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  logic             active;
  logic [CNT_W-1:0] byteCnt;

  always_comb begin
    strobes.firstByte = byteValid && byteStart;
    strobes.nextByte  = byteValid && !byteStart && active;
    strobes.lastByte  = strobes.nextByte && (byteCnt == CNT_W'(ADDR_BYTES - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      byteCnt <= '0;
    end else if (strobes.firstByte) begin
      active  <= 1'b1;
      byteCnt <= CNT_W'(1);
    end else if (strobes.lastByte) begin
      active  <= 1'b0;
      byteCnt <= '0;
    end else if (strobes.nextByte) begin
      byteCnt <= byteCnt + CNT_W'(1);
    end
  end

  // R9: after the last byte collection stops until the next start
  assert_stop_after_last_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lastByte |=> !active);

  // R9: idle state always carries a zero count
  assert_idle_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> byteCnt == '0);

endmodule

// File: rtl/mhf_datapath.sv
module mhf_datapath
  import mhf_pkg::*;
#(
  parameter int          ADDR_BYTES = 6,
  parameter int          HASH_BITS  = 6,
  parameter logic [31:0] CRC_POLY   = 32'hEDB88320
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  mhfStrobes_t                         strobes,
  input  logic [7:0]                          byteData,
  input  logic                                tableHiWr,
  input  logic                                tableLoWr,
  input  logic [((1 << HASH_BITS) / 2)-1:0]   tableWrData,
  input  logic                                promiscEn,
  input  logic [8*ADDR_BYTES-1:0]             stationAddr,
  output logic                                decisionValid,
  output logic                                accept
);
  localparam int TABLE_BITS = 1 << HASH_BITS;
  localparam int HALF_BITS  = TABLE_BITS / 2;
  localparam int ADDR_W     = 8 * ADDR_BYTES;

  logic [31:0]           crcReg;
  logic [31:0]           crcNext;
  logic [ADDR_W-1:0]     addrReg;
  logic [ADDR_W-1:0]     fullAddr;
  logic                  groupFlag;
  logic                  groupNow;
  logic [HASH_BITS-1:0]  hashIdx;
  logic [TABLE_BITS-1:0] tableBits;
  logic                  hashHit;
  logic                  decision;
  logic [HALF_BITS-1:0]  tableHalf [2];

  // Hash table: index 1 is the upper half, index 0 the lower half.
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic wrEn;
    assign wrEn = (h == 1) ? tableHiWr : tableLoWr;
    always_ff @(posedge clk) begin
      if (!rstN)     tableHalf[h] <= '0;
      else if (wrEn) tableHalf[h] <= tableWrData;
    end
  end

  assign tableBits = {tableHalf[1], tableHalf[0]};

  // CRC update for the byte in flight; a first byte starts from all ones.
  assign crcNext  = crcFeedByte(strobes.firstByte ? 32'hFFFF_FFFF : crcReg, byteData, CRC_POLY);
  assign hashIdx  = crcNext[31 -: HASH_BITS];
  assign hashHit  = tableBits[hashIdx];
  assign fullAddr = {addrReg[ADDR_W-9:0], byteData};
  assign groupNow = groupFlag;

  always_comb begin
    if (promiscEn)     decision = 1'b1;
    else if (groupNow) decision = hashHit;
    else               decision = (fullAddr == stationAddr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg    <= '1;
      addrReg   <= '0;
      groupFlag <= 1'b0;
    end else if (strobes.firstByte) begin
      crcReg    <= crcNext;
      addrReg   <= ADDR_W'(byteData);
      groupFlag <= byteData[0];
    end else if (strobes.nextByte) begin
      crcReg    <= crcNext;
      addrReg   <= fullAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decisionValid <= 1'b0;
      accept        <= 1'b0;
    end else begin
      decisionValid <= strobes.lastByte;
      accept        <= strobes.lastByte && decision;
    end
  end

  // R6: promiscuous mode in the last byte cycle forces acceptance
  assert_promisc_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid && $past(promiscEn) |-> accept);

  // R8: the decision strobe lasts one cycle
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid |=> !decisionValid);

  // R8: accept is never seen without the strobe
  assert_accept_qualified_R8: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> decisionValid);

  // R5: an empty table rejects every group address
  assert_empty_table_R5: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid && groupFlag && !$past(promiscEn) && $past(tableBits) == '0 |-> !accept);

  // R10: a write to the upper half lands at the next edge
  assert_table_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(tableHiWr) |-> tableHalf[1] == $past(tableWrData));

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
#(
  parameter int          ADDR_BYTES = 6,
  parameter int          HASH_BITS  = 6,
  parameter logic [31:0] CRC_POLY   = 32'hEDB88320
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              byteValid,
  input  logic                              byteStart,
  input  logic [7:0]                        byteData,
  input  logic                              tableHiWr,
  input  logic                              tableLoWr,
  input  logic [((1 << HASH_BITS) / 2)-1:0] tableWrData,
  input  logic                              promiscEn,
  input  logic [8*ADDR_BYTES-1:0]           stationAddr,
  output logic                              decisionValid,
  output logic                              accept
);
  mhfStrobes_t strobes;

  mhf_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .byteStart (byteStart),
    .strobes   (strobes)
  );

  mhf_datapath #(
    .ADDR_BYTES (ADDR_BYTES),
    .HASH_BITS  (HASH_BITS),
    .CRC_POLY   (CRC_POLY)
  ) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .byteData      (byteData),
    .tableHiWr     (tableHiWr),
    .tableLoWr     (tableLoWr),
    .tableWrData   (tableWrData),
    .promiscEn     (promiscEn),
    .stationAddr   (stationAddr),
    .decisionValid (decisionValid),
    .accept        (accept)
  );

endmodule

// File: tb/mcast_hash_filter_bench.sv
module mcast_hash_filter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic        byteStart = 1'b0;
  logic [7:0]  byteData = '0;
  logic        tableHiWr = 1'b0;
  logic        tableLoWr = 1'b0;
  logic [31:0] tableWrData = '0;
  logic        promiscEn = 1'b0;
  logic [47:0] stationAddr = 48'h02_11_22_33_44_56;
  logic        decisionValid;
  logic        accept;

  int total = 0;
  int bad = 0;
  logic [31:0] modelHi = '0;
  logic [31:0] modelLo = '0;
  logic lastDv, lastAcc;

  always #2.5 clk = ~clk;

  mcast_hash_filter u_mcast_hash_filter (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteStart(byteStart),
    .byteData(byteData), .tableHiWr(tableHiWr), .tableLoWr(tableLoWr),
    .tableWrData(tableWrData), .promiscEn(promiscEn), .stationAddr(stationAddr),
    .decisionValid(decisionValid), .accept(accept)
  );

  function automatic logic [5:0] refIndex(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] d = a[47 - 8*i -: 8];
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ d[b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c[31:26];
  endfunction

  function automatic logic refAccept(input logic [47:0] a, input logic p);
    logic [5:0] idx = refIndex(a);
    if (p) return 1'b1;
    if (a[40]) return (idx >= 6'd32) ? modelHi[idx - 6'd32] : modelLo[idx[4:0]];
    return a == stationAddr;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeTable(input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    tableHiWr = 1'b1; tableLoWr = 1'b1; tableWrData = hi;
    @(negedge clk);
    tableLoWr = 1'b0; tableHiWr = 1'b0;
    tableLoWr = 1'b1; tableWrData = lo;
    @(negedge clk);
    tableLoWr = 1'b0;
    modelHi = hi; modelLo = lo;
  endtask

  // Drives n bytes of a, optionally marking the first; samples outputs after the last.
  task automatic sendRaw(input logic [47:0] a, input int n, input bit withStart, input int gapMax);
    for (int i = 0; i < n; i++) begin
      byteValid = 1'b1;
      byteStart = withStart && (i == 0);
      byteData  = a[47 - 8*i -: 8];
      @(negedge clk);
      byteValid = 1'b0; byteStart = 1'b0;
      lastDv = decisionValid; lastAcc = accept;
      if (i != n - 1 && gapMax > 0) repeat ($urandom_range(gapMax, 0)) @(negedge clk);
    end
  endtask

  task automatic runFrame(input logic [47:0] a, input string req, input int gapMax);
    logic exp = refAccept(a, promiscEn);
    sendRaw(a, 6, 1'b1, gapMax);
    check({req, " decision strobe (R8)"}, 32'(lastDv), 32'd1);
    check({req, " accept"}, 32'(lastAcc), 32'(exp));
    @(negedge clk);
    check({req, " strobe one cycle (R8)"}, 32'(decisionValid), 32'd0);
  endtask

  function automatic logic [47:0] findGroup(input bit wantHigh);
    logic [47:0] a;
    do begin
      a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      a[40] = 1'b1;
    end while ((refIndex(a) >= 6'd32) != wantHigh);
    return a;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] a;
    logic [5:0]  ix;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1 reset decisionValid", 32'(decisionValid), 32'd0);
    check("R1 reset accept", 32'(accept), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: cleared table rejects a group address
    runFrame(48'h01_00_5E_00_00_01, "R1 cleared table", 0);
    check("R1 group rejected after reset", 32'(lastAcc), 32'd0);

    // R2/R3: single set bit in the upper half, then in the lower half
    a = findGroup(1'b1); ix = refIndex(a);
    writeTable(32'd1 << (ix - 6'd32), 32'd0);
    runFrame(a, "R2 R3 high half single bit", 1);
    check("R3 high half hit", 32'(lastAcc), 32'd1);
    writeTable(~(32'd1 << (ix - 6'd32)), 32'hFFFF_FFFF);
    runFrame(a, "R3 high half single hole", 1);
    check("R3 high half miss", 32'(lastAcc), 32'd0);
    a = findGroup(1'b0); ix = refIndex(a);
    writeTable(32'd0, 32'd1 << ix[4:0]);
    runFrame(a, "R2 R3 low half single bit", 2);
    check("R3 low half hit", 32'(lastAcc), 32'd1);
    writeTable(32'hFFFF_FFFF, ~(32'd1 << ix[4:0]));
    runFrame(a, "R3 low half single hole", 0);
    check("R3 low half miss", 32'(lastAcc), 32'd0);

    // R5: all ones and all zeros
    writeTable(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) begin
      runFrame(findGroup(k[0]), "R5 all ones", 1);
      check("R5 all ones accepts", 32'(lastAcc), 32'd1);
    end

    // R4/R7: individual addresses ignore the table
    a = 48'h02_00_00_00_00_01;
    runFrame(a, "R4 R7 individual, odd last byte", 0);
    check("R4 group bit only in first byte", 32'(lastAcc), 32'd0);
    runFrame(stationAddr, "R7 station match", 2);
    check("R7 station accepted", 32'(lastAcc), 32'd1);
    runFrame(stationAddr ^ 48'h00_00_00_01_00_00, "R7 one bit off", 0);
    check("R7 near miss rejected", 32'(lastAcc), 32'd0);

    writeTable(32'd0, 32'd0);
    for (int k = 0; k < 6; k++) begin
      runFrame(findGroup(k[0]), "R5 all zeros", 1);
      check("R5 all zeros rejects", 32'(lastAcc), 32'd0);
    end

    // R6: promiscuous
    promiscEn = 1'b1;
    runFrame(findGroup(1'b1), "R6 promisc group", 0);
    runFrame(48'h02_AA_BB_CC_DD_EE, "R6 promisc individual", 1);
    check("R6 promisc accepts", 32'(lastAcc), 32'd1);
    promiscEn = 1'b0;

    // R9: restart mid-address; decision follows the second address
    sendRaw(stationAddr, 3, 1'b1, 0);
    check("R9 no decision on partial", 32'(lastDv), 32'd0);
    runFrame(48'h02_AA_BB_CC_DD_EE, "R9 restart", 0);
    check("R9 restart uses new address", 32'(lastAcc), 32'd0);
    // R9: bytes after the sixth and idle bytes are ignored
    sendRaw(stationAddr, 6, 1'b1, 0);
    @(negedge clk);
    sendRaw(stationAddr, 6, 1'b0, 0);
    check("R9 extra bytes ignored", 32'(lastDv), 32'd0);
    @(negedge clk);
    check("R9 no late decision", 32'(decisionValid), 32'd0);

    // R10: table update applies to the next address
    a = findGroup(1'b0); ix = refIndex(a);
    writeTable(32'd0, 32'd1 << ix[4:0]);
    runFrame(a, "R10 after write", 0);
    check("R10 new table used", 32'(lastAcc), 32'd1);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(7, 0) == 0) writeTable($urandom, $urandom);
      promiscEn = ($urandom_range(7, 0) == 0);
      case ($urandom_range(3, 0))
        0: a = stationAddr;
        default: a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      endcase
      runFrame(a, "R2 R4 R7 random", 2);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule